// File: doc/BRIEF.md
# GPIO Pin Function and Override Multiplexer

This block routes signals between a bank of general-purpose pins and a set of on-chip peripheral functions. Each pin has a 5-bit function selector. The selector picks which peripheral supplies the pin's output level and output enable, and which peripheral receives the pin's input. After the selection, four independent 2-bit override stages can invert or force the output, the output enable, the input delivered to the peripheral and the interrupt line. Two pad-control bits per pin set the pad behaviour: an output-disable bit and an input-enable bit.

Software reaches the block through a plain word-addressed register port, with no back-pressure. A write is captured on the clock edge while `cfg_we` is high. A read returns data combinationally from `cfg_addr`. Each pin owns four words at address `{pin, word}`:

- word 0 is the control word.
- word 1 is the read-only status word. It shows every signal both before and after its override.
- word 2 is the pad-control word.
- word 3 is reserved.

All peripheral-side vectors are flattened so that bit `f*NPINS+p` belongs to function `f` and pin `p`.

Top module: `pinmux_bank`

## Requirements
- R1: After reset, every control word reads 0x0000001F, meaning no function is selected and all overrides are 0. Every pad word reads 0x80, meaning output disable is set and input enable is clear. `pad_oe_o` and `pad_out_o` are 0.
- R2: A function select value f in the range 0 to NFUNC-1 drives the pin's output from `func_out_i[f*NPINS+p]` and its output enable from `func_oe_i[f*NPINS+p]`, before any override.
- R3: A function select value of NFUNC or above, including 0x1F, gives 0 for both the pre-override output and the pre-override output enable. It also gives 0 on every `func_in_o` line of that pin.
- R4: The output override (control bits 9:8) works as follows: 0 passes the selected output, 1 inverts it, 2 forces it low and 3 forces it high.
- R5: The output-enable override (control bits 13:12) works as follows: 0 passes the selected enable, 1 inverts it, 2 forces it off and 3 forces it on.
- R6: The pad input is ANDed with input enable (pad bit 6) before the input override is applied. The input override (control bits 17:16) uses the encoding 0 pass, 1 invert, 2 force low, 3 force high. The result reaches only `func_in_o[f*NPINS+p]` for the selected f, and every other function's line is 0.
- R7: The interrupt line `irq_o[p]` is the raw pad input, which input enable does not affect. The interrupt override (control bits 29:28) is then applied with the encoding 0 pass, 1 invert, 2 force low, 3 force high.
- R8: When output disable (pad bit 7) is set, `pad_oe_o[p]` is 0 whatever the select and the overrides give.
- R9: The status word carries eight signals, and every other bit reads 0:
  - bit 8: output before its override
  - bit 9: output after its override
  - bit 12: enable before its override
  - bit 13: final pad enable
  - bit 17: gated input before its override
  - bit 19: input after its override
  - bit 24: raw interrupt source
  - bit 26: interrupt after its override
- R10: Register access follows these rules:
  - Only the defined control fields (4:0, 9:8, 13:12, 17:16, 29:28) and pad bits 7:6 are stored, and all other bits read 0.
  - Writes to the status word, to the reserved word, or to a pin index of NPINS or above change nothing.
  - Those reserved addresses read 0.
  - A write takes effect from the clock edge that captures it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Word address {pin, word} |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Combinational read data |
| func_out_i | input | NFUNC*NPINS | Peripheral output levels, bit f*NPINS+p |
| func_oe_i | input | NFUNC*NPINS | Peripheral output enables, bit f*NPINS+p |
| func_in_o | output | NFUNC*NPINS | Pin inputs delivered to peripherals |
| pad_in_i | input | NPINS | Levels seen at the pads |
| pad_out_o | output | NPINS | Output levels to the pads |
| pad_oe_o | output | NPINS | Output enables to the pads |
| irq_o | output | NPINS | Per-pin interrupt lines after override |

## Verification
The routing is tested by giving two candidate functions opposite levels on the same pin and switching between them. This shows whether the selector, and not some fixed source, drives the pin. Each override code is applied to an input whose passed value is the opposite of the forced value, so pass, invert and force each produce a distinct answer. Input gating is told apart from override order by clearing input enable and then inverting: a gated-then-inverted input reads 1, and an inverted-then-gated input would read 0. Unattached selectors are tried with every peripheral driving 1, and the status word is read under two configurations whose pre- and post-override values differ bit by bit.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;

  localparam int FSEL_W = 5;
  localparam logic [FSEL_W-1:0] FSEL_NONE = 5'h1F;

  typedef enum logic [1:0] {
    OVR_PASS = 2'd0,
    OVR_INV  = 2'd1,
    OVR_LO   = 2'd2,
    OVR_HI   = 2'd3
  } ovr_e;

  typedef struct packed {
    ovr_e              irq;
    ovr_e              inp;
    ovr_e              oe;
    ovr_e              out;
    logic [FSEL_W-1:0] fsel;
  } ctrl_t;

  typedef struct packed {
    logic od;
    logic ie;
  } pad_t;

  // control word field positions (software-visible)
  localparam int CB_OUT = 8;
  localparam int CB_OE  = 12;
  localparam int CB_IN  = 16;
  localparam int CB_IRQ = 28;
  // pad word bit positions
  localparam int PB_OD = 7;
  localparam int PB_IE = 6;
  // status word bit positions
  localparam int ST_OUT_PRE  = 8;
  localparam int ST_OUT_POST = 9;
  localparam int ST_OE_PRE   = 12;
  localparam int ST_OE_PAD   = 13;
  localparam int ST_IN_PRE   = 17;
  localparam int ST_IN_POST  = 19;
  localparam int ST_IRQ_PRE  = 24;
  localparam int ST_IRQ_POST = 26;

  // per-pin word selector inside the {pin, word} address
  localparam logic [1:0] W_CTRL = 2'd0;
  localparam logic [1:0] W_STAT = 2'd1;
  localparam logic [1:0] W_PAD  = 2'd2;

  localparam ctrl_t CTRL_RST = '{irq: OVR_PASS, inp: OVR_PASS, oe: OVR_PASS,
                                 out: OVR_PASS, fsel: FSEL_NONE};
  localparam pad_t  PAD_RST  = '{od: 1'b1, ie: 1'b0};

  function automatic logic apply_ovr(logic s, ovr_e m);
    case (m)
      OVR_INV: return ~s;
      OVR_LO:  return 1'b0;
      OVR_HI:  return 1'b1;
      default: return s;
    endcase
  endfunction

  function automatic logic [31:0] ctrl_to_word(ctrl_t c);
    logic [31:0] w;
    w = '0;
    w[FSEL_W-1:0]      = c.fsel;
    w[CB_OUT+1:CB_OUT] = c.out;
    w[CB_OE+1:CB_OE]   = c.oe;
    w[CB_IN+1:CB_IN]   = c.inp;
    w[CB_IRQ+1:CB_IRQ] = c.irq;
    return w;
  endfunction

  function automatic ctrl_t word_to_ctrl(logic [31:0] w);
    ctrl_t c;
    c.fsel = w[FSEL_W-1:0];
    c.out  = ovr_e'(w[CB_OUT+1:CB_OUT]);
    c.oe   = ovr_e'(w[CB_OE+1:CB_OE]);
    c.inp  = ovr_e'(w[CB_IN+1:CB_IN]);
    c.irq  = ovr_e'(w[CB_IRQ+1:CB_IRQ]);
    return c;
  endfunction

endpackage

// File: rtl/pinmux_cfg_regs.sv
module pinmux_cfg_regs
  import pinmux_pkg::*;
#(
  parameter int NPINS = 30,
  parameter int PIN_W = $clog2(NPINS),
  localparam int ADDR_W = PIN_W + 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_we,
  input  logic [ADDR_W-1:0]           cfg_addr,
  input  logic [31:0]                 cfg_wdata,
  output logic [31:0]                 cfg_rdata,
  input  logic [NPINS-1:0][31:0]      status_i,
  output ctrl_t [NPINS-1:0]           ctrl_o,
  output pad_t  [NPINS-1:0]           pad_o
);

  ctrl_t [NPINS-1:0] ctrl_q;
  pad_t  [NPINS-1:0] pad_q;

  logic [PIN_W-1:0] pin_idx;
  logic [1:0]       word_sel;
  logic             pin_hit;
  logic             unused_wdata;

  assign pin_idx      = cfg_addr[ADDR_W-1:2];
  assign word_sel     = cfg_addr[1:0];
  assign pin_hit      = (32'(pin_idx) < NPINS);
  assign unused_wdata = ^cfg_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NPINS; p++) begin
        ctrl_q[p] <= CTRL_RST;
        pad_q[p]  <= PAD_RST;
      end
    end else if (cfg_we && pin_hit) begin
      if (word_sel == W_CTRL) ctrl_q[pin_idx] <= word_to_ctrl(cfg_wdata);
      if (word_sel == W_PAD)  pad_q[pin_idx]  <= '{od: cfg_wdata[PB_OD], ie: cfg_wdata[PB_IE]};
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (pin_hit) begin
      case (word_sel)
        W_CTRL: cfg_rdata = ctrl_to_word(ctrl_q[pin_idx]);
        W_STAT: cfg_rdata = status_i[pin_idx];
        W_PAD: begin
          cfg_rdata[PB_OD] = pad_q[pin_idx].od;
          cfg_rdata[PB_IE] = pad_q[pin_idx].ie;
        end
        default: cfg_rdata = '0;
      endcase
    end
  end

  assign ctrl_o = ctrl_q;
  assign pad_o  = pad_q;

  // R10: writes to status, reserved words or absent pins leave all state untouched
  p_dead_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && (!pin_hit || word_sel == W_STAT || word_sel == 2'd3))
      |=> ($stable(ctrl_q) && $stable(pad_q)));

endmodule

// File: rtl/pinmux_lane.sv
module pinmux_lane
  import pinmux_pkg::*;
#(
  parameter int NFUNC = 10
) (
  input  ctrl_t             ctrl,
  input  pad_t              pad,
  input  logic              pad_in,
  input  logic [NFUNC-1:0]  fout,
  input  logic [NFUNC-1:0]  foe,
  output logic              pad_out,
  output logic              pad_oe,
  output logic              irq,
  output logic [NFUNC-1:0]  fin,
  output logic [31:0]       status
);

  logic [NFUNC-1:0] sel_hot;
  logic out_pre, oe_pre, in_pre, in_post, oe_post, irq_pre;

  for (genvar f = 0; f < NFUNC; f++) begin : g_sel
    assign sel_hot[f] = (ctrl.fsel == FSEL_W'(f));
  end

  // unattached selectors leave sel_hot all-zero, so both sources read 0
  assign out_pre = |(sel_hot & fout);
  assign oe_pre  = |(sel_hot & foe);

  assign pad_out = apply_ovr(out_pre, ctrl.out);
  assign oe_post = apply_ovr(oe_pre, ctrl.oe);
  assign pad_oe  = oe_post & ~pad.od;

  assign in_pre  = pad_in & pad.ie;
  assign in_post = apply_ovr(in_pre, ctrl.inp);
  assign fin     = sel_hot & {NFUNC{in_post}};

  assign irq_pre = pad_in;
  assign irq     = apply_ovr(irq_pre, ctrl.irq);

  always_comb begin
    status              = '0;
    status[ST_OUT_PRE]  = out_pre;
    status[ST_OUT_POST] = pad_out;
    status[ST_OE_PRE]   = oe_pre;
    status[ST_OE_PAD]   = pad_oe;
    status[ST_IN_PRE]   = in_pre;
    status[ST_IN_POST]  = in_post;
    status[ST_IRQ_PRE]  = irq_pre;
    status[ST_IRQ_POST] = irq;
  end

endmodule

// File: rtl/pinmux_bank.sv
module pinmux_bank
  import pinmux_pkg::*;
#(
  parameter int NPINS = 30,
  parameter int NFUNC = 10,
  localparam int PIN_W  = $clog2(NPINS),
  localparam int ADDR_W = PIN_W + 2,
  localparam int FV_W   = NFUNC * NPINS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic [FV_W-1:0]   func_out_i,
  input  logic [FV_W-1:0]   func_oe_i,
  output logic [FV_W-1:0]   func_in_o,
  input  logic [NPINS-1:0]  pad_in_i,
  output logic [NPINS-1:0]  pad_out_o,
  output logic [NPINS-1:0]  pad_oe_o,
  output logic [NPINS-1:0]  irq_o
);

  ctrl_t [NPINS-1:0]        ctrl;
  pad_t  [NPINS-1:0]        pad;
  logic  [NPINS-1:0][31:0]  status;

  pinmux_cfg_regs #(.NPINS(NPINS), .PIN_W(PIN_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata),
    .status_i (status),
    .ctrl_o   (ctrl),
    .pad_o    (pad)
  );

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic [NFUNC-1:0] fout_v, foe_v, fin_v;

    for (genvar f = 0; f < NFUNC; f++) begin : g_fn
      assign fout_v[f]              = func_out_i[f*NPINS+p];
      assign foe_v[f]               = func_oe_i[f*NPINS+p];
      assign func_in_o[f*NPINS+p]   = fin_v[f];
    end

    pinmux_lane #(.NFUNC(NFUNC)) u_lane (
      .ctrl   (ctrl[p]),
      .pad    (pad[p]),
      .pad_in (pad_in_i[p]),
      .fout   (fout_v),
      .foe    (foe_v),
      .pad_out(pad_out_o[p]),
      .pad_oe (pad_oe_o[p]),
      .irq    (irq_o[p]),
      .fin    (fin_v),
      .status (status[p])
    );

    // R8: output disable in the pad word wins over every override
    p_od_blocks_oe_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pad[p].od |-> !pad_oe_o[p]);

    // R6: a pin's input reaches at most one peripheral
    p_fin_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(fin_v));

    // R6: with input enable clear and no override, no peripheral sees the pin
    p_ie_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!pad[p].ie && ctrl[p].inp == OVR_PASS) |-> (fin_v == '0));

    // R3: unattached selector with pass-through output drives nothing
    p_unattached_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((32'(ctrl[p].fsel) >= NFUNC) && ctrl[p].out == OVR_PASS && ctrl[p].oe == OVR_PASS)
        |-> (!pad_out_o[p] && !pad_oe_o[p]));

    // R7: forced interrupt codes dominate the pad level
    p_irq_force_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl[p].irq == OVR_HI) |-> irq_o[p]);
  end

endmodule

// File: tb/pinmux_bank_test.sv
`timescale 1ns/1ps
module pinmux_bank_test;

  localparam int NP = 30;
  localparam int NF = 10;
  localparam int AW = 7;
  localparam int FW = NP * NF;
  localparam int P  = 3;

  localparam int K_RD = 0, K_OUT = 1, K_OE = 2, K_IRQ = 3, K_FIN = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [FW-1:0] func_out = '0, func_oe = '0, func_in;
  logic [NP-1:0] pad_in = '0, pad_out, pad_oe, irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pinmux_bank uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .func_out_i(func_out), .func_oe_i(func_oe), .func_in_o(func_in),
    .pad_in_i(pad_in), .pad_out_o(pad_out), .pad_oe_o(pad_oe), .irq_o(irq)
  );

  typedef struct {
    int          kind;
    int          idx;
    logic [31:0] exp;
    string       req;
  } item_t;

  item_t sb[$];
  event  sb_ev;

  function automatic int fi(int f, int p);
    return f * NP + p;
  endfunction

  function automatic logic [31:0] probe(int kind, int idx);
    case (kind)
      K_RD:    return cfg_rdata;
      K_OUT:   return {31'b0, pad_out[idx]};
      K_OE:    return {31'b0, pad_oe[idx]};
      K_IRQ:   return {31'b0, irq[idx]};
      default: return {31'b0, func_in[idx]};
    endcase
  endfunction

  // monitor: pops expected items and compares them with the design's outputs
  initial begin
    forever begin
      @(sb_ev);
      while (sb.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it  = sb.pop_front();
        act = probe(it.kind, it.idx);
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s kind=%0d idx=%0d actual=0x%08h expected=0x%08h",
                   it.req, it.kind, it.idx, act, it.exp);
        end
      end
    end
  end

  task automatic expect_val(int kind, int idx, logic [31:0] exp, string req);
    item_t it;
    it.kind = kind; it.idx = idx; it.exp = exp; it.req = req;
    sb.push_back(it);
    ->sb_ev;
    #1;
  endtask

  task automatic cfg_write(int pin, int word, logic [31:0] data);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_addr  = AW'((pin << 2) | word);
    cfg_wdata = data;
    @(negedge clk);
    cfg_we    = 1'b0;
    #1;
  endtask

  task automatic read_expect(int pin, int word, logic [31:0] exp, string req);
    cfg_addr = AW'((pin << 2) | word);
    #1;
    expect_val(K_RD, 0, exp, req);
  endtask

  task automatic set_pad_in(logic v);
    pad_in[P] = v;
    #1;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;

    // R1: reset state
    read_expect(P, 0, 32'h0000_001F, "R1 ctrl reset");
    read_expect(P, 2, 32'h0000_0080, "R1 pad reset");
    expect_val(K_OE, P, 0, "R1 oe reset");
    expect_val(K_OUT, P, 0, "R1 out reset");

    // R2: selection between two functions driving opposite levels
    cfg_write(P, 2, 32'h40);
    func_out[fi(2,P)] = 1'b1; func_oe[fi(2,P)] = 1'b1;
    func_out[fi(5,P)] = 1'b0; func_oe[fi(5,P)] = 1'b1;
    cfg_write(P, 0, 32'd2);
    expect_val(K_OUT, P, 1, "R2 fsel2 out");
    expect_val(K_OE, P, 1, "R2 fsel2 oe");
    cfg_write(P, 0, 32'd5);
    expect_val(K_OUT, P, 0, "R2 fsel5 out");
    expect_val(K_OE, P, 1, "R2 fsel5 oe");

    // R6: input routed only to the selected function
    set_pad_in(1'b1);
    expect_val(K_FIN, fi(5,P), 1, "R6 fin selected");
    expect_val(K_FIN, fi(2,P), 0, "R6 fin other");

    // R4: output override codes
    cfg_write(P, 0, 32'd5 | (32'd1 << 8));
    expect_val(K_OUT, P, 1, "R4 invert");
    func_out[fi(5,P)] = 1'b1;
    cfg_write(P, 0, 32'd5 | (32'd2 << 8));
    expect_val(K_OUT, P, 0, "R4 force low");
    func_out[fi(5,P)] = 1'b0;
    cfg_write(P, 0, 32'd5 | (32'd3 << 8));
    expect_val(K_OUT, P, 1, "R4 force high");

    // R5: output-enable override codes
    cfg_write(P, 0, 32'd5 | (32'd2 << 12));
    expect_val(K_OE, P, 0, "R5 force off");
    func_oe[fi(5,P)] = 1'b0;
    cfg_write(P, 0, 32'd5 | (32'd3 << 12));
    expect_val(K_OE, P, 1, "R5 force on");
    cfg_write(P, 0, 32'd5 | (32'd1 << 12));
    expect_val(K_OE, P, 1, "R5 invert of 0");
    func_oe[fi(5,P)] = 1'b1;
    #1;
    expect_val(K_OE, P, 0, "R5 invert of 1");

    // R8: output disable beats forced enable
    cfg_write(P, 0, 32'd5 | (32'd3 << 12));
    cfg_write(P, 2, 32'hC0);
    expect_val(K_OE, P, 0, "R8 od wins");

    // R6: gating before override
    cfg_write(P, 2, 32'h00);
    cfg_write(P, 0, 32'd5);
    expect_val(K_FIN, fi(5,P), 0, "R6 ie gate");
    cfg_write(P, 0, 32'd5 | (32'd1 << 16));
    expect_val(K_FIN, fi(5,P), 1, "R6 gate then invert");
    cfg_write(P, 2, 32'h40);
    cfg_write(P, 0, 32'd5 | (32'd2 << 16));
    expect_val(K_FIN, fi(5,P), 0, "R6 force low");
    set_pad_in(1'b0);
    cfg_write(P, 0, 32'd5 | (32'd3 << 16));
    expect_val(K_FIN, fi(5,P), 1, "R6 force high");

    // R7: interrupt override, raw source
    set_pad_in(1'b1);
    cfg_write(P, 0, 32'd5);
    expect_val(K_IRQ, P, 1, "R7 pass");
    cfg_write(P, 0, 32'd5 | (32'd1 << 28));
    expect_val(K_IRQ, P, 0, "R7 invert");
    cfg_write(P, 0, 32'd5 | (32'd2 << 28));
    expect_val(K_IRQ, P, 0, "R7 force low");
    set_pad_in(1'b0);
    cfg_write(P, 0, 32'd5 | (32'd3 << 28));
    expect_val(K_IRQ, P, 1, "R7 force high");
    cfg_write(P, 2, 32'h00);
    cfg_write(P, 0, 32'd5);
    set_pad_in(1'b1);
    expect_val(K_IRQ, P, 1, "R7 ignores ie");

    // R3: unattached selectors with every peripheral driving 1
    func_out = '1; func_oe = '1;
    cfg_write(P, 2, 32'h40);
    cfg_write(P, 0, 32'd12);
    expect_val(K_OUT, P, 0, "R3 fsel12 out");
    expect_val(K_OE, P, 0, "R3 fsel12 oe");
    for (int f = 0; f < NF; f++) expect_val(K_FIN, fi(f,P), 0, "R3 fsel12 fin");
    cfg_write(P, 0, 32'h1F);
    expect_val(K_OUT, P, 0, "R3 fsel1F out");
    cfg_write(P, 0, 32'd9);
    expect_val(K_OUT, P, 1, "R2 last function");

    // R9: status word readback
    func_oe[fi(2,P)] = 1'b0;
    cfg_write(P, 0, 32'h3001_0102);
    read_expect(P, 1, 32'h0502_0100, "R9 status a");
    func_oe[fi(2,P)] = 1'b1;
    set_pad_in(1'b0);
    cfg_write(P, 2, 32'hC0);
    cfg_write(P, 0, 32'd2);
    read_expect(P, 1, 32'h0000_1300, "R9 status b");

    // R10: register access rules
    cfg_write(0, 0, 32'hFFFF_FFFF);
    read_expect(0, 0, 32'h3003_331F, "R10 ctrl mask");
    expect_val(K_OE, 0, 0, "R8 reset od on pin0");
    cfg_write(0, 1, 32'hFFFF_FFFF);
    read_expect(0, 0, 32'h3003_331F, "R10 status write ignored ctrl");
    read_expect(0, 2, 32'h0000_0080, "R10 status write ignored pad");
    cfg_write(29, 2, 32'hFFFF_FFFF);
    read_expect(29, 2, 32'h0000_00C0, "R10 pad mask last pin");
    cfg_write(29, 3, 32'hFFFF_FFFF);
    read_expect(29, 3, 32'h0, "R10 reserved word");
    cfg_write(30, 0, 32'h0);
    read_expect(30, 0, 32'h0, "R10 absent pin");
    read_expect(29, 0, 32'h0000_001F, "R10 absent pin no alias");

    #20;
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule